// File: doc/BRIEF.md
# Dual-Mode Host Bus Port with Bus-Style Detection

This block is the parallel slave port that a host processor uses to reach the register and memory space of a switching device. It works in two wirings. In the first, a separate six-bit address bus and an eight-bit data bus carry each transfer. In the second, one eight-bit bus carries the address and then the data, and an address strobe separates the two phases. In the multiplexed wiring the port works out for itself whether the host drives Motorola-style strobes (data strobe plus read/write level) or Intel-style strobes (separate read and write pulses). It reads the level of the shared read/data-strobe pin at the moment the address strobe rises.

Addresses with the top bit clear reach four eight-bit registers. Addresses with the top bit set open a window onto an external memory. A control register chooses which memory the window reaches and which per-stream page of it. That memory can be one of two connection memories or a data memory that can only be read. The port drives single-cycle read and write strobes to the memories. It drives the shared bus only while a read is in progress, and it signals a data acknowledge for one clock per transfer. All bus pins are sampled on the device clock.

Top module: `host_port`

## Requirements
- R1: After reset the control register reads 0x00, `split_o` and `msg_o` are low, `dta_n_o` is high, `ad_oe_o` is low, no memory strobe is active, and the multiplexed strobe style is Motorola until the first address strobe.
- R2: With `mux_mode_i` low, the address comes from `addr_i`. A transfer starts on the first clock where `cs_n_i` and `ds_rd_n_i` are both low. `rw_wr_n_i` high makes it a read and low makes it a write, with write data on `ad_i`.
- R3: With `mux_mode_i` high, `ad_i[5:0]` is captured when `as_i` rises. That address is used by every transfer until the next rise of `as_i`.
- R4: On a rise of `as_i` in multiplexed mode, `ds_rd_n_i` low selects Motorola strobes and `ds_rd_n_i` high selects Intel strobes. The chosen style holds until the next rise of `as_i`.
- R5: In Intel style, with `cs_n_i` low, a falling `ds_rd_n_i` (read) or a falling `rw_wr_n_i` (write) starts a transfer.
- R6: With address bit 5 clear, offsets 0, 1, 2 and 3 reach the control, interface-mode, stream-pair and frame-offset registers, each eight bits and readable and writable. Other offsets read as 0x00, and writes to them change no register.
- R7: Control register layout: bit 7 is the split flag (`split_o`), bit 6 the message flag (`msg_o`), bits 5:4 the memory select (00 none, 01 data memory, 10 connection low, 11 connection high), and bits 3:0 the stream page.
- R8: With address bit 5 set, a write whose memory select is 10 or 11 raises `mem_wr_o` for exactly one clock. It presents `mem_addr_o` = {page, address[4:0]}, `mem_sel_o` = the memory select and `mem_wdata_o` = the write data. `mem_wr_o` and `mem_rd_o` are never high together.
- R9: A memory-window write with memory select 01 (data memory) or 00 produces no `mem_wr_o` pulse. A memory-window read with select 00 produces no `mem_rd_o` pulse and returns 0x00.
- R10: A memory-window read with a non-zero memory select raises `mem_rd_o` for one clock and drives `mem_rdata_i` onto `ad_o` while the read strobe is held.
- R11: `dta_n_o` goes low for exactly one clock, the clock after a transfer starts. It stays high when `cs_n_i` is high. `ad_oe_o` is high only during a read transfer.
- R12: A strobe held active for several clocks performs one transfer only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock; all bus pins are sampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_mode_i | input | 1 | 0: separate address bus, 1: multiplexed address/data |
| cs_n_i | input | 1 | Chip select, active low |
| as_i | input | 1 | Address strobe / latch enable; rising edge captures address |
| ds_rd_n_i | input | 1 | Motorola data strobe or Intel read strobe, active low |
| rw_wr_n_i | input | 1 | Motorola read/write level or Intel write strobe |
| addr_i | input | 6 | Address in non-multiplexed mode |
| ad_i | input | 8 | Data in; address in multiplexed address phase |
| ad_o | output | 8 | Read data out |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| dta_n_o | output | 1 | Data acknowledge, active low |
| split_o | output | 1 | Split flag from control register |
| msg_o | output | 1 | Message flag from control register |
| imode_o | output | 8 | Interface-mode register contents |
| pair_o | output | 8 | Stream-pair register contents |
| fofs_o | output | 8 | Frame-offset register contents |
| mem_addr_o | output | 9 | Memory address {page, offset} |
| mem_sel_o | output | 2 | Memory select for the current access |
| mem_wr_o | output | 1 | One-clock memory write strobe |
| mem_rd_o | output | 1 | One-clock memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data |

## Verification
The bench runs register traffic in all three bus styles. It switches style between transfers and then repeats transfers without a new address strobe. A port that does not latch the style or the address would then mis-read strobes or hit the wrong register. It tries Intel-style write strobes before any address strobe has been seen, which a port that does not default to Motorola would accept. It aims writes at the data memory and at an empty memory select, where a missing read-only guard shows up as a stray write pulse. It holds strobes for two clocks and checks that the acknowledge and memory strobes are single pulses, and it checks that a transfer with chip select high is ignored.

// File: rtl/hp_pkg.sv
package hp_pkg;

  localparam int HP_DATA_W = 8;
  localparam int HP_ADDR_W = 6;
  localparam int HP_PAGE_W = 4;
  localparam int HP_NUM_REGS = 4;

  localparam int REG_CTRL  = 0;
  localparam int REG_IMODE = 1;
  localparam int REG_PAIR  = 2;
  localparam int REG_FOFS  = 3;

  typedef enum logic {
    STYLE_MOTO  = 1'b0,
    STYLE_INTEL = 1'b1
  } bus_style_e;

  typedef enum logic [1:0] {
    MSEL_NONE    = 2'b00,
    MSEL_DATA    = 2'b01,
    MSEL_CONN_LO = 2'b10,
    MSEL_CONN_HI = 2'b11
  } mem_sel_e;

  typedef struct packed {
    logic                 split;
    logic                 msg;
    mem_sel_e             msel;
    logic [HP_PAGE_W-1:0] page;
  } ctrl_reg_t;

endpackage

// File: rtl/hp_style_detect.sv
module hp_style_detect
  import hp_pkg::*;
#(
  parameter int ADDR_W = HP_ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mux_mode_i,
  input  logic              as_i,
  input  logic              ds_rd_n_i,
  input  logic [ADDR_W-1:0] ad_addr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output bus_style_e        style_o,
  output logic [ADDR_W-1:0] addr_o
);

  logic              as_q;
  logic              as_rise;
  bus_style_e        style_q, style_d;
  logic [ADDR_W-1:0] lat_q, lat_d;

  assign as_rise = mux_mode_i && as_i && !as_q;

  always_comb begin
    style_d = style_q;
    lat_d   = lat_q;
    if (as_rise) begin
      style_d = ds_rd_n_i ? STYLE_INTEL : STYLE_MOTO;
      lat_d   = ad_addr_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_q    <= 1'b0;
      style_q <= STYLE_MOTO;
      lat_q   <= '0;
    end else begin
      as_q    <= as_i;
      style_q <= style_d;
      lat_q   <= lat_d;
    end
  end

  assign style_o = mux_mode_i ? style_q : STYLE_MOTO;
  assign addr_o  = mux_mode_i ? lat_q : addr_i;

  // R4
  style_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mux_mode_i && as_i && !as_q) |=> $stable(style_q));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mux_mode_i && as_i && !as_q) |=> $stable(lat_q));

endmodule

// File: rtl/hp_access_ctl.sv
module hp_access_ctl
  import hp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_style_e style_i,
  input  logic       cs_n_i,
  input  logic       ds_rd_n_i,
  input  logic       rw_wr_n_i,
  output logic       start_o,
  output logic       is_read_o,
  output logic       rd_act_o,
  output logic       dta_n_o
);

  logic qual;
  logic qual_q;
  logic rd_act_q, rd_act_d;
  logic dta_q;

  always_comb begin
    if (style_i == STYLE_INTEL) begin
      qual      = !cs_n_i && (!ds_rd_n_i || !rw_wr_n_i);
      is_read_o = !ds_rd_n_i;
    end else begin
      qual      = !cs_n_i && !ds_rd_n_i;
      is_read_o = rw_wr_n_i;
    end
  end

  assign start_o = qual && !qual_q;

  always_comb begin
    if (start_o)   rd_act_d = is_read_o;
    else if (qual) rd_act_d = rd_act_q;
    else           rd_act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qual_q   <= 1'b0;
      rd_act_q <= 1'b0;
      dta_q    <= 1'b0;
    end else begin
      qual_q   <= qual;
      rd_act_q <= rd_act_d;
      dta_q    <= start_o;
    end
  end

  assign rd_act_o = rd_act_q;
  assign dta_n_o  = !dta_q;

  // R11
  dta_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dta_n_o |=> dta_n_o);

  // R11
  dta_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dta_n_o |-> $past(!cs_n_i));

endmodule

// File: rtl/hp_reg_bank.sv
module hp_reg_bank
  import hp_pkg::*;
#(
  parameter int DATA_W   = HP_DATA_W,
  parameter int ADDR_W   = HP_ADDR_W,
  parameter int PAGE_W   = HP_PAGE_W,
  parameter int NUM_REGS = HP_NUM_REGS,
  localparam int OFS_W   = ADDR_W - 1,
  localparam int MADDR_W = PAGE_W + OFS_W,
  localparam int REG_IW  = $clog2(NUM_REGS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               is_read_i,
  input  logic               rd_act_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  mem_rdata_i,
  output logic [DATA_W-1:0]  ad_o,
  output logic               split_o,
  output logic               msg_o,
  output logic [DATA_W-1:0]  imode_o,
  output logic [DATA_W-1:0]  pair_o,
  output logic [DATA_W-1:0]  fofs_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [1:0]         mem_sel_o,
  output logic               mem_wr_o,
  output logic               mem_rd_o,
  output logic [DATA_W-1:0]  mem_wdata_o
);

  localparam logic [OFS_W-1:0] NREG_L = OFS_W'(NUM_REGS);

  logic [DATA_W-1:0]  regs_q [NUM_REGS];
  logic [DATA_W-1:0]  regs_d [NUM_REGS];
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               src_mem_q, src_mem_d;
  logic [MADDR_W-1:0] maddr_q, maddr_d;
  logic [1:0]         msel_q, msel_d;
  logic [DATA_W-1:0]  mwdata_q, mwdata_d;
  logic               mwr_q, mwr_d;
  logic               mrd_q, mrd_d;

  ctrl_reg_t        ctrl;
  logic             win_mem;
  logic [OFS_W-1:0] ofs;
  logic             reg_hit;
  logic             mem_ok;
  logic             wr_stb;
  logic             rd_stb;

  assign ctrl    = ctrl_reg_t'(regs_q[REG_CTRL]);
  assign win_mem = addr_i[ADDR_W-1];
  assign ofs     = addr_i[OFS_W-1:0];
  assign reg_hit = !win_mem && (ofs < NREG_L);
  assign mem_ok  = win_mem && (ctrl.msel != MSEL_NONE);
  assign wr_stb  = start_i && !is_read_i;
  assign rd_stb  = start_i && is_read_i;

  always_comb begin
    regs_d = regs_q;
    if (wr_stb && reg_hit) regs_d[ofs[REG_IW-1:0]] = wdata_i;
  end

  always_comb begin
    rdata_d   = rdata_q;
    src_mem_d = src_mem_q;
    if (rd_stb) begin
      rdata_d   = reg_hit ? regs_q[ofs[REG_IW-1:0]] : '0;
      src_mem_d = mem_ok;
    end
  end

  always_comb begin
    maddr_d  = maddr_q;
    msel_d   = msel_q;
    mwdata_d = mwdata_q;
    if (start_i && win_mem) begin
      maddr_d  = {ctrl.page, ofs};
      msel_d   = ctrl.msel;
      mwdata_d = wdata_i;
    end
    mwr_d = wr_stb && mem_ok && (ctrl.msel != MSEL_DATA);
    mrd_d = rd_stb && mem_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      rdata_q   <= '0;
      src_mem_q <= 1'b0;
      maddr_q   <= '0;
      msel_q    <= '0;
      mwdata_q  <= '0;
      mwr_q     <= 1'b0;
      mrd_q     <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_d[i];
      rdata_q   <= rdata_d;
      src_mem_q <= src_mem_d;
      maddr_q   <= maddr_d;
      msel_q    <= msel_d;
      mwdata_q  <= mwdata_d;
      mwr_q     <= mwr_d;
      mrd_q     <= mrd_d;
    end
  end

  assign ad_o        = rd_act_i ? (src_mem_q ? mem_rdata_i : rdata_q) : '0;
  assign split_o     = ctrl.split;
  assign msg_o       = ctrl.msg;
  assign imode_o     = regs_q[REG_IMODE];
  assign pair_o      = regs_q[REG_PAIR];
  assign fofs_o      = regs_q[REG_FOFS];
  assign mem_addr_o  = maddr_q;
  assign mem_sel_o   = msel_q;
  assign mem_wr_o    = mwr_q;
  assign mem_rd_o    = mrd_q;
  assign mem_wdata_o = mwdata_q;

  // R9
  data_mem_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (mem_sel_o != MSEL_DATA) && (mem_sel_o != MSEL_NONE));

  // R12
  mem_wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> !mem_wr_o);

  // R8
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_o && mem_rd_o));

  // R7
  ctrl_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_q[REG_CTRL]) |-> $past(start_i && !is_read_i));

endmodule

// File: rtl/host_port.sv
module host_port
  import hp_pkg::*;
#(
  parameter int DATA_W   = HP_DATA_W,
  parameter int ADDR_W   = HP_ADDR_W,
  parameter int PAGE_W   = HP_PAGE_W,
  localparam int MADDR_W = PAGE_W + ADDR_W - 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mux_mode_i,
  input  logic               cs_n_i,
  input  logic               as_i,
  input  logic               ds_rd_n_i,
  input  logic               rw_wr_n_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  ad_i,
  output logic [DATA_W-1:0]  ad_o,
  output logic               ad_oe_o,
  output logic               dta_n_o,
  output logic               split_o,
  output logic               msg_o,
  output logic [DATA_W-1:0]  imode_o,
  output logic [DATA_W-1:0]  pair_o,
  output logic [DATA_W-1:0]  fofs_o,
  output logic [MADDR_W-1:0] mem_addr_o,
  output logic [1:0]         mem_sel_o,
  output logic               mem_wr_o,
  output logic               mem_rd_o,
  output logic [DATA_W-1:0]  mem_wdata_o,
  input  logic [DATA_W-1:0]  mem_rdata_i
);

  logic              rst_meta_q, rst_sync_q;
  bus_style_e        style;
  logic [ADDR_W-1:0] acc_addr;
  logic              start, is_read, rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  hp_style_detect #(.ADDR_W(ADDR_W)) style_i (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .mux_mode_i(mux_mode_i),
    .as_i      (as_i),
    .ds_rd_n_i (ds_rd_n_i),
    .ad_addr_i (ad_i[ADDR_W-1:0]),
    .addr_i    (addr_i),
    .style_o   (style),
    .addr_o    (acc_addr)
  );

  hp_access_ctl access_i (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .style_i  (style),
    .cs_n_i   (cs_n_i),
    .ds_rd_n_i(ds_rd_n_i),
    .rw_wr_n_i(rw_wr_n_i),
    .start_o  (start),
    .is_read_o(is_read),
    .rd_act_o (rd_act),
    .dta_n_o  (dta_n_o)
  );

  hp_reg_bank #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W),
    .PAGE_W(PAGE_W)
  ) regs_i (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .start_i    (start),
    .is_read_i  (is_read),
    .rd_act_i   (rd_act),
    .addr_i     (acc_addr),
    .wdata_i    (ad_i),
    .mem_rdata_i(mem_rdata_i),
    .ad_o       (ad_o),
    .split_o    (split_o),
    .msg_o      (msg_o),
    .imode_o    (imode_o),
    .pair_o     (pair_o),
    .fofs_o     (fofs_o),
    .mem_addr_o (mem_addr_o),
    .mem_sel_o  (mem_sel_o),
    .mem_wr_o   (mem_wr_o),
    .mem_rd_o   (mem_rd_o),
    .mem_wdata_o(mem_wdata_o)
  );

  assign ad_oe_o = rd_act;

  // R11
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    ad_oe_o |-> !cs_n_i || $past(!cs_n_i));

  // R1
  strobes_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $rose(rst_sync_q) |-> dta_n_o && !ad_oe_o && !mem_wr_o && !mem_rd_o);

endmodule

// File: tb/host_port_tb.sv
module host_port_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mux = 1'b0, cs_n = 1'b1, as_s = 1'b0, ds = 1'b1, rw = 1'b1;
  logic [5:0] addr = '0;
  logic [7:0] ad_in = '0;
  logic [7:0] ad_out, imode, pair, fofs, mwdata, mrdata;
  logic       ad_oe, dta_n, split, msg, mwr, mrd;
  logic [8:0] maddr;
  logic [1:0] msel;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign mrdata = maddr[7:0] ^ {msel, 6'b0};

  host_port dut_i (
    .clk(clk), .rst_n(rst_n), .mux_mode_i(mux), .cs_n_i(cs_n), .as_i(as_s),
    .ds_rd_n_i(ds), .rw_wr_n_i(rw), .addr_i(addr), .ad_i(ad_in),
    .ad_o(ad_out), .ad_oe_o(ad_oe), .dta_n_o(dta_n), .split_o(split),
    .msg_o(msg), .imode_o(imode), .pair_o(pair), .fofs_o(fofs),
    .mem_addr_o(maddr), .mem_sel_o(msel), .mem_wr_o(mwr), .mem_rd_o(mrd),
    .mem_wdata_o(mwdata), .mem_rdata_i(mrdata)
  );

  logic       g_dta, g_oe, g_wr, g_rd, g_dta2, g_wr2, g_rd2, g_oe2;
  logic [7:0] g_ad, g_wd;
  logic [8:0] g_ma;
  logic [1:0] g_ms;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // mode: 0 separate address bus, 1 multiplexed Motorola, 2 multiplexed Intel
  task automatic access(input int mode, input bit do_as, input bit rd,
                        input logic [5:0] a, input logic [7:0] wd);
    mux = (mode != 0);
    if (mode != 0 && do_as) begin
      @(negedge clk); ad_in = {2'b00, a}; ds = (mode == 2); as_s = 1'b1;
      @(negedge clk); as_s = 1'b0; ds = 1'b1;
    end
    @(negedge clk);
    cs_n = 1'b0; addr = a; ad_in = wd;
    if (mode == 2) begin
      if (rd) ds = 1'b0; else rw = 1'b0;
    end else begin
      rw = rd; ds = 1'b0;
    end
    @(negedge clk);
    g_dta = dta_n; g_ad = ad_out; g_oe = ad_oe; g_wr = mwr; g_rd = mrd;
    g_ma = maddr; g_ms = msel; g_wd = mwdata;
    @(negedge clk);
    g_dta2 = dta_n; g_wr2 = mwr; g_rd2 = mrd; g_oe2 = ad_oe;
    cs_n = 1'b1; ds = 1'b1; rw = 1'b1;
    @(negedge clk);
  endtask

  // mode[24:23] rd[22] addr[21:16] wdata[15:8] expected[7:0]
  localparam int NV = 10;
  localparam logic [24:0] VEC [NV] = '{
    {2'd0, 1'b0, 6'h01, 8'hA5, 8'h00},
    {2'd0, 1'b1, 6'h01, 8'h00, 8'hA5},
    {2'd1, 1'b0, 6'h02, 8'h3C, 8'h00},
    {2'd1, 1'b1, 6'h02, 8'h00, 8'h3C},
    {2'd2, 1'b0, 6'h03, 8'hC3, 8'h00},
    {2'd2, 1'b1, 6'h03, 8'h00, 8'hC3},
    {2'd0, 1'b1, 6'h03, 8'h00, 8'hC3},
    {2'd2, 1'b0, 6'h1F, 8'hFF, 8'h00},
    {2'd0, 1'b1, 6'h1F, 8'h00, 8'h00},
    {2'd1, 1'b1, 6'h01, 8'h00, 8'hA5}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 dta idle", dta_n, 1);
    chk("R1 oe idle", ad_oe, 0);
    chk("R1 split", split, 0);
    chk("R1 msg", msg, 0);
    chk("R1 mem strobes", {mwr, mrd}, 0);

    // R1 default Motorola: Intel write pattern before any address strobe is ignored
    @(negedge clk); mux = 1'b1; cs_n = 1'b0; ds = 1'b1; rw = 1'b0; ad_in = 8'hFF;
    @(negedge clk); chk("R1 no Intel before strobe", dta_n, 1);
    @(negedge clk); cs_n = 1'b1; rw = 1'b1;
    access(0, 0, 1, 6'h00, 8'h00);
    chk("R1 control reads zero", g_ad, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      tag = (v[24:23] == 0) ? "R2" : (v[24:23] == 1) ? "R3 R4" : "R5";
      access(int'(v[24:23]), 1, v[22], v[21:16], v[15:8]);
      chk({tag, " R11 dta low"}, g_dta, 0);
      chk({tag, " R11 R12 dta single"}, g_dta2, 1);
      chk({tag, " R8 no mem write in reg window"}, g_wr, 0);
      if (v[22]) begin
        chk({tag, " R6 read data"}, g_ad, v[7:0]);
        chk({tag, " R11 oe during read"}, g_oe, 1);
      end else begin
        chk({tag, " R11 oe off on write"}, g_oe, 0);
      end
    end
    chk("R6 imode port", imode, 8'hA5);
    chk("R6 pair port", pair, 8'h3C);
    chk("R6 fofs port", fofs, 8'hC3);

    // R7 control fields
    access(0, 0, 0, 6'h00, 8'hE5);
    chk("R7 split", split, 1);
    chk("R7 msg", msg, 1);
    access(0, 0, 1, 6'h00, 8'h00);
    chk("R7 readback", g_ad, 8'hE5);

    // R8 connection-low write
    access(0, 0, 0, 6'h2A, 8'h5A);
    chk("R8 write pulse", g_wr, 1);
    chk("R8 mem addr", g_ma, 9'h0AA);
    chk("R8 mem sel", g_ms, 2'b10);
    chk("R8 wdata", g_wd, 8'h5A);
    chk("R12 write once", g_wr2, 0);

    // R10 connection-high read via Intel multiplexed
    access(0, 0, 0, 6'h00, 8'h33);
    access(2, 1, 1, 6'h21, 8'h00);
    chk("R10 read pulse", g_rd, 1);
    chk("R10 mem addr", g_ma, 9'h061);
    chk("R10 data", g_ad, 8'hA1);
    chk("R12 read once", g_rd2, 0);
    // R3 R4 address and Intel style held without new strobe
    access(2, 0, 1, 6'h00, 8'h00);
    chk("R3 R4 held address and style", g_ad, 8'hA1);

    // R4 switch to Motorola: Intel write pattern ignored afterwards
    access(1, 1, 1, 6'h01, 8'h00);
    chk("R4 moto read", g_ad, 8'hA5);
    access(2, 0, 0, 6'h01, 8'h11);
    chk("R4 Intel strobe ignored in Motorola", g_dta, 1);
    access(0, 0, 1, 6'h01, 8'h00);
    chk("R4 imode unchanged", g_ad, 8'hA5);

    // R9 data memory is read-only
    access(0, 0, 0, 6'h00, 8'h17);
    access(0, 0, 0, 6'h25, 8'h77);
    chk("R9 data mem write blocked", {g_wr, g_wr2}, 0);
    access(0, 0, 1, 6'h25, 8'h00);
    chk("R10 data mem read pulse", g_rd, 1);
    chk("R10 data mem read value", g_ad, 8'hA5);

    // R9 no memory selected
    access(0, 0, 0, 6'h00, 8'h00);
    access(0, 0, 0, 6'h30, 8'h44);
    chk("R9 none select write", {g_wr, g_wr2}, 0);
    access(0, 0, 1, 6'h30, 8'h00);
    chk("R9 none select no read", g_rd, 0);
    chk("R9 none select data", g_ad, 8'h00);

    // R11 chip select high: no transfer
    @(negedge clk); mux = 1'b0; addr = 6'h01; ds = 1'b0; rw = 1'b0; ad_in = 8'h99;
    @(negedge clk); chk("R11 no dta without cs", dta_n, 1);
    @(negedge clk); ds = 1'b1; rw = 1'b1;
    access(0, 0, 1, 6'h01, 8'h00);
    chk("R11 write ignored without cs", g_ad, 8'hA5);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule